// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, for every memory access a hart issues, whether the access may proceed or must fault. It keeps a table of protection entries. Each entry has an 8-bit configuration byte (permissions, match mode, lock) and a 32-bit address register holding a byte address divided by four. Software-side logic fills the table through a single indexed register port. The access side presents a byte address, an access kind and a machine-mode flag. One cycle later the block returns a registered allow/fault result.

Each entry matches either a top-of-range window or a naturally aligned power-of-two region. The lowest-numbered matching entry settles the outcome. A lock bit freezes an entry against further writes, and it also makes that entry's permissions apply to machine mode. When an entry is locked in top-of-range mode, the address register of the entry below it is frozen too, because that register supplies the window's lower bound.

Top module: `memprot_checker`

## Requirements
- R1: After reset every configuration byte and every address register reads zero, and `res_valid` is low.
- R2: With `reg_sel`=0, the register port writes the low byte of `reg_wdata` into configuration entry `reg_idx` and reads it back zero-extended. With `reg_sel`=1 it writes and reads all 32 bits of address register `reg_idx`. Reserved bits 6:5 and the reserved mode value are stored exactly as written.
- R3: Configuration fields are: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (0 off, 1 top-of-range, 3 power-of-two), bit 7 lock. A top-of-range entry i matches word address w = addr[33:2] when lower <= w < its own register. The lower bound is 0 for entry 0 and the register of entry i-1 otherwise.
- R4: A power-of-two entry with register value A matches every address whose word address agrees with A above its trailing-ones run plus one bit. So zero trailing ones gives 8 bytes, k trailing ones gives 2^(k+3) bytes, and all ones covers the whole space.
- R5: For an unlocked matching entry, a machine-mode access (`chk_mach`=1) is allowed regardless of the permission bits.
- R6: While an entry's lock bit is set, writes to its configuration byte and to its address register leave both unchanged.
- R7: While entry i+1 is locked in top-of-range mode, writes to address register i are ignored. A locked power-of-two entry i+1 does not protect register i.
- R8: When several entries match, the lowest-numbered one decides the result.
- R9: When no entry matches, a machine-mode access is allowed and a lower-privilege access faults.
- R10: Entries in mode 0 or mode 2 never match.
- R11: For a matching entry that is locked or accessed at lower privilege, the result is its permission bit for the kind. Kind codes are 0 read, 1 write, 2 execute.
- R12: Access kind code 3 always faults.
- R13: A request with `chk_valid` high yields `res_valid` high with its `res_allow` on the next clock edge. `res_valid` is low after an edge with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects configuration byte, 1 selects address register |
| reg_idx | input | 4 | Entry index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| chk_valid | input | 1 | Access request present |
| chk_addr | input | 34 | Byte address of the access |
| chk_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| chk_mach | input | 1 | 1 for machine mode, 0 for lower privilege |
| res_valid | output | 1 | Result present |
| res_allow | output | 1 | 1 allow, 0 fault |

## Verification
On every cycle, the assertions check that locked entries and lock-protected lower bounds do not change. They also check that the winning entry is the lowest matching one, that unmatched and reserved-kind accesses resolve as required, and that an unlocked entry never blocks machine mode. Whether the address windows themselves are right can only be shown by the bench's directed scenarios. These cover the top-of-range edges, power-of-two sizes from 8 bytes up to the full space, overlapping entries, and the register readback after locked writes.

// File: rtl/memprot_pkg.sv
`timescale 1ns/1ps
package memprot_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_RSVD  = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  // bit 7 lock, 6:5 reserved, 4:3 mode, 2 x, 1 w, 0 r
  typedef struct packed {
    logic        lock;
    logic [1:0]  rsvd;
    match_mode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } entry_cfg_t;
endpackage

// File: rtl/memprot_regs.sv
`timescale 1ns/1ps
module memprot_regs
  import memprot_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(N)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      sel_addr,
  input  logic [IW-1:0]             idx,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  output entry_cfg_t [N-1:0]        cfg_o,
  output logic [N-1:0][AW-1:0]      addr_o
);
  entry_cfg_t [N-1:0]   cfg_q, cfg_d;
  logic [N-1:0][AW-1:0] addr_q, addr_d;
  logic [N-1:0]         cfg_wr, addr_wr, addr_frozen;

  for (genvar i = 0; i < N; i++) begin : g_ent
    if (i < N - 1) begin : g_upper
      assign addr_frozen[i] = cfg_q[i].lock |
                              (cfg_q[i+1].lock && cfg_q[i+1].mode == MODE_TOR);
    end else begin : g_top
      assign addr_frozen[i] = cfg_q[i].lock;
    end
    assign cfg_wr[i]  = wr_en && !sel_addr && (idx == IW'(i)) && !cfg_q[i].lock;
    assign addr_wr[i] = wr_en &&  sel_addr && (idx == IW'(i)) && !addr_frozen[i];

    always_comb begin
      cfg_d[i]  = cfg_wr[i]  ? entry_cfg_t'(wdata[7:0]) : cfg_q[i];
      addr_d[i] = addr_wr[i] ? wdata[AW-1:0]            : addr_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i]  <= '0;
        addr_q[i] <= '0;
      end else begin
        if (cfg_wr[i])  cfg_q[i]  <= cfg_d[i];
        if (addr_wr[i]) addr_q[i] <= addr_d[i];
      end
    end

    a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[i].lock |=> $stable(cfg_q[i]));
    a_r6_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[i].lock |=> $stable(addr_q[i]));
    if (i < N - 1) begin : g_chk
      a_r7_tor_lower_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[i+1].lock && cfg_q[i+1].mode == MODE_TOR) |=> $stable(addr_q[i]));
    end
  end

  always_comb begin
    if (sel_addr) rdata = DW'(addr_q[idx]);
    else          rdata = {{(DW-8){1'b0}}, cfg_q[idx]};
  end

  assign cfg_o  = cfg_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/memprot_match.sv
`timescale 1ns/1ps
module memprot_match
  import memprot_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 32
) (
  input  logic [AW-1:0]        word_addr,
  input  logic [N-1:0][1:0]    mode,
  input  logic [N-1:0][AW-1:0] bound,
  output logic [N-1:0]         hit
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [AW-1:0] lower, care;
    logic          tor_hit, napot_hit;

    if (i == 0) begin : g_first
      assign lower = '0;
    end else begin : g_rest
      assign lower = bound[i-1];
    end

    // bits at and below the first zero of the register are don't-care
    assign care      = ~(bound[i] ^ (bound[i] + AW'(1)));
    assign tor_hit   = (word_addr >= lower) && (word_addr < bound[i]);
    assign napot_hit = ((word_addr ^ bound[i]) & care) == '0;

    always_comb begin
      unique case (match_mode_e'(mode[i]))
        MODE_TOR:   hit[i] = tor_hit;
        MODE_NAPOT: hit[i] = napot_hit;
        default:    hit[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/memprot_decide.sv
`timescale 1ns/1ps
module memprot_decide
  import memprot_pkg::*;
#(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]      hit,
  input  logic [N-1:0][2:0] perm,
  input  logic [N-1:0]      lock,
  input  logic [1:0]        kind,
  input  logic              mach,
  output logic              any_hit,
  output logic [IW-1:0]     win_idx,
  output logic              allow
);
  logic [2:0] win_perm;
  logic       perm_bit;

  always_comb begin
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) win_idx = IW'(i);
    end
  end

  assign any_hit  = |hit;
  assign win_perm = perm[win_idx];

  always_comb begin
    unique case (acc_kind_e'(kind))
      KIND_READ:  perm_bit = win_perm[0];
      KIND_WRITE: perm_bit = win_perm[1];
      KIND_EXEC:  perm_bit = win_perm[2];
      default:    perm_bit = 1'b0;
    endcase
  end

  always_comb begin
    if (acc_kind_e'(kind) == KIND_RSVD)   allow = 1'b0;
    else if (!any_hit)                    allow = mach;
    else if (mach && !lock[win_idx])      allow = 1'b1;
    else                                  allow = perm_bit;
  end
endmodule

// File: rtl/memprot_checker.sv
`timescale 1ns/1ps
module memprot_checker
  import memprot_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_sel,
  input  logic [IW-1:0] reg_idx,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          chk_valid,
  input  logic [AW+1:0] chk_addr,
  input  logic [1:0]    chk_kind,
  input  logic          chk_mach,
  output logic          res_valid,
  output logic          res_allow
);
  entry_cfg_t [N-1:0]   cfg;
  logic [N-1:0][AW-1:0] bound;
  logic [N-1:0][1:0]    mode;
  logic [N-1:0][2:0]    perm;
  logic [N-1:0]         lock, hit;
  logic [N-1:0][1:0]    unused_rsvd;
  logic [1:0]           unused_ofs;
  logic                 any_hit, allow;
  logic [IW-1:0]        win_idx;
  logic                 res_valid_q, res_valid_d, res_allow_q, res_allow_d;

  memprot_regs #(.N(N), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .sel_addr(reg_sel),
    .idx(reg_idx), .wdata(reg_wdata), .rdata(reg_rdata),
    .cfg_o(cfg), .addr_o(bound)
  );

  for (genvar i = 0; i < N; i++) begin : g_split
    assign mode[i]        = cfg[i].mode;
    assign perm[i]        = {cfg[i].x, cfg[i].w, cfg[i].r};
    assign lock[i]        = cfg[i].lock;
    assign unused_rsvd[i] = cfg[i].rsvd;
  end
  assign unused_ofs = chk_addr[1:0];

  memprot_match #(.N(N), .AW(AW)) u_match (
    .word_addr(chk_addr[AW+1:2]), .mode(mode), .bound(bound), .hit(hit)
  );

  memprot_decide #(.N(N)) u_decide (
    .hit(hit), .perm(perm), .lock(lock), .kind(chk_kind), .mach(chk_mach),
    .any_hit(any_hit), .win_idx(win_idx), .allow(allow)
  );

  always_comb begin
    res_valid_d = chk_valid;
    res_allow_d = chk_valid ? allow : res_allow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_allow_q <= 1'b0;
    end else begin
      res_valid_q <= res_valid_d;
      if (chk_valid) res_allow_q <= res_allow_d;
    end
  end

  assign res_valid = res_valid_q;
  assign res_allow = res_allow_q;

  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (hit[win_idx] && ((hit & ((N'(1) << win_idx) - N'(1))) == '0)));
  a_r9_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_hit && chk_kind != 2'd3) |-> (allow == chk_mach));
  a_r5_unlocked_machine: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && chk_mach && !lock[win_idx] && chk_kind != 2'd3) |-> allow);
  a_r12_reserved_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_kind == 2'd3) |-> !allow);
  a_r13_latency: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> (res_valid && res_allow == $past(allow)));
  a_r13_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !res_valid);
endmodule

// File: tb/sim_memprot_checker.sv
`timescale 1ns/1ps
module sim_memprot_checker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, reg_sel;
  logic [3:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic        chk_valid, chk_mach;
  logic [33:0] chk_addr;
  logic [1:0]  chk_kind;
  logic        res_valid, res_allow;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;

  always #2 clk = ~clk;

  memprot_checker u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_kind(chk_kind),
    .chk_mach(chk_mach), .res_valid(res_valid), .res_allow(res_allow)
  );

  function automatic logic [31:0] cfgb(bit r, bit w, bit x, bit [1:0] m, bit l);
    return 32'({l, 2'b00, m, x, w, r});
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_we = 0; reg_sel = 0; reg_idx = 0; reg_wdata = 0;
    chk_valid = 0; chk_addr = 0; chk_kind = 0; chk_mach = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(bit sel, int idx, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_idx = 4'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_chk(bit sel, int idx, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_sel = sel; reg_idx = 4'(idx);
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic acc(logic [33:0] a, logic [1:0] k, bit m, bit exp, string tag);
    @(negedge clk);
    chk_addr = a; chk_kind = k; chk_mach = m; chk_valid = 1;
    @(negedge clk);
    chk_valid = 0;
    chk(tag, 32'(res_allow), 32'(exp));
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 res_valid", 32'(res_valid), 0);
    rd_chk(0, 0, 0, "R1 cfg0");
    rd_chk(1, 5, 0, "R1 addr5");
    rd_chk(0, 15, 0, "R1 cfg15");
    acc(34'h100, 2'd0, 0, 0, "R9 user no match");
    acc(34'h100, 2'd1, 1, 1, "R9 machine no match");
  endtask

  task automatic t_regs();
    do_reset();
    wr(0, 3, 32'hABCD_EF75);
    rd_chk(0, 3, 32'h75, "R2 cfg readback");
    wr(1, 3, 32'hDEAD_BEEF);
    rd_chk(1, 3, 32'hDEAD_BEEF, "R2 addr readback");
    wr(1, 3, 32'hFFFF_FFFF);
    acc(34'h1234, 2'd0, 0, 0, "R10 mode2 no match");
    wr(0, 4, cfgb(1, 1, 1, 2'd0, 0));
    wr(1, 4, 32'hFFFF_FFFF);
    acc(34'h40, 2'd1, 0, 0, "R10 mode0 no match");
  endtask

  task automatic t_tor();
    do_reset();
    wr(1, 0, 32'h400);
    wr(0, 0, cfgb(1, 0, 0, 2'd1, 0));
    wr(1, 1, 32'hC00);
    wr(0, 1, cfgb(1, 1, 0, 2'd1, 0));
    acc(34'h0,    2'd0, 0, 1, "R3 tor0 low edge");
    acc(34'hFFC,  2'd0, 0, 1, "R3 tor0 top word");
    acc(34'hFFC,  2'd1, 0, 0, "R11 tor0 no write");
    acc(34'h1000, 2'd1, 0, 1, "R3 tor1 lower bound");
    acc(34'h2FFC, 2'd1, 0, 1, "R3 tor1 top word");
    acc(34'h3000, 2'd0, 0, 0, "R3 tor1 bound excluded");
  endtask

  task automatic t_napot();
    do_reset();
    wr(1, 0, 32'h800);
    wr(0, 0, cfgb(0, 0, 1, 2'd3, 0));
    wr(1, 1, 32'h41FF);
    wr(0, 1, cfgb(1, 0, 0, 2'd3, 0));
    acc(34'h2004,  2'd2, 0, 1, "R4 8B inside");
    acc(34'h2008,  2'd2, 0, 0, "R4 8B outside");
    acc(34'h2000,  2'd0, 0, 0, "R11 no read perm");
    acc(34'h2000,  2'd1, 1, 1, "R5 machine unlocked");
    acc(34'h10FFC, 2'd0, 0, 1, "R4 4K inside");
    acc(34'h11000, 2'd0, 0, 0, "R4 4K above");
    acc(34'hFFFC,  2'd0, 0, 0, "R4 4K below");
    wr(1, 2, 32'hFFFF_FFFF);
    wr(0, 2, cfgb(1, 1, 1, 2'd3, 0));
    acc(34'h11000,    2'd0, 0, 1, "R4 all ones");
    acc(34'h3_FFFF_FFFC, 2'd1, 0, 1, "R4 all ones top");
    acc(34'h2000,  2'd0, 0, 0, "R8 lowest wins");
    acc(34'h10000, 2'd1, 0, 0, "R8 entry1 over entry2");
  endtask

  task automatic t_lock();
    do_reset();
    wr(1, 0, 32'h100);
    wr(1, 1, 32'h800);
    wr(0, 1, cfgb(1, 0, 0, 2'd1, 1));
    wr(0, 1, 32'h0);
    rd_chk(0, 1, 32'h89, "R6 cfg write ignored");
    wr(1, 1, 32'h5);
    rd_chk(1, 1, 32'h800, "R6 addr write ignored");
    wr(1, 0, 32'h7);
    rd_chk(1, 0, 32'h100, "R7 lower bound frozen");
    acc(34'h1000, 2'd1, 1, 0, "R11 locked machine write");
    acc(34'h1000, 2'd0, 1, 1, "R11 locked machine read");
    acc(34'h300,  2'd1, 1, 1, "R9 below window machine");
    wr(1, 2, 32'h55);
    wr(0, 3, cfgb(0, 0, 0, 2'd3, 1));
    wr(1, 2, 32'h66);
    rd_chk(1, 2, 32'h66, "R7 napot lock leaves lower");
  endtask

  task automatic t_kind();
    do_reset();
    acc(34'h40, 2'd3, 1, 0, "R12 machine no match");
    wr(1, 0, 32'hFFFF_FFFF);
    wr(0, 0, cfgb(1, 1, 1, 2'd3, 0));
    acc(34'h40, 2'd3, 0, 0, "R12 user full perms");
    acc(34'h40, 2'd3, 1, 0, "R12 machine match");
  endtask

  task automatic t_timing();
    do_reset();
    @(negedge clk);
    chk_addr = 34'h40; chk_kind = 2'd0; chk_mach = 1; chk_valid = 1;
    @(negedge clk);
    chk_valid = 0;
    chk("R13 valid after request", 32'(res_valid), 1);
    chk("R13 allow with valid", 32'(res_allow), 1);
    @(negedge clk);
    chk("R13 valid drops", 32'(res_valid), 0);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_tor();
    t_napot();
    t_lock();
    t_kind();
    t_timing();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule